// File: doc/BRIEF.md
# I2C Bus Condition Controller

This block sits on the two open-drain wires of an I2C bus for a single controller port. It watches the clock and data lines through a synchronizer and recognizes start and stop conditions. Each condition is recorded in its own sticky status flag, which software can clear. A second function generates the serial clock for a transfer, tracks the position within each nine-clock frame, and creates start and stop conditions on request.

A start request is held until the bus is known to be free. The bus counts as free when a stop has been observed and both lines are high. Only then does the controller pull data low, and after a hold time it pulls clock low. A stop request is carried out at the end of the next clock-low phase.

While the controller clocks the bus, any target may hold the clock low to insert a wait. The controller does not time its high phase, and does not advance, until it sees the line high. Outputs are drive enables: a 1 pulls the wire low, and a 0 releases it.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset both drive enables are 0, start_seen is 0, stop_seen is 1, bit_count is 0, ack_slot is 0, and both pending bits are 0.
- R2: A falling edge on data while the clock is high (judged on synchronized samples) sets start_seen and clears stop_seen. Data changes while the clock is low change neither flag.
- R3: A rising edge on data while the clock is high sets stop_seen and clears start_seen.
- R4: A one-cycle pulse on start_flag_clr clears start_seen, and a one-cycle pulse on stop_flag_clr clears stop_seen.
- R5: A start request made while stop_seen is 0 stays pending (start_pending = 1), and neither line is driven until a stop is observed.
- R6: Once a pending start sees stop_seen = 1 and both lines high, sda_oe rises first. scl_oe follows exactly HOLD_CYC cycles later. start_pending returns to 0 once the clock is seen low, and the block's own start sets start_seen.
- R7: While clocking with no stretching, scl_oe stays 1 for LOW_CYC cycles, then 0 for HIGH_CYC + SYNC_STAGES + 1 cycles.
- R8: While another device holds the clock low after the controller has released it, scl_oe stays 0 and bit_count does not change. After the line is freed, bit_count advances by one.
- R9: bit_count steps 1, 2, …, 9 on each synchronized rising clock edge. It wraps from 9 back to 1, and returns to 0 on any start or stop condition. ack_slot is 1 exactly while bit_count is 9.
- R10: A stop request accepted during a transfer sets stop_pending. At the next end of a low phase, data is pulled low, the clock is released, and data is released only with the clock high. stop_seen is then set, start_seen is cleared, bit_count is 0, and both enables and stop_pending are 0.
- R11: A stop request while the controller is idle is ignored: stop_pending stays 0 and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle request to issue a start condition |
| stop_req | input | 1 | One-cycle request to issue a stop condition |
| start_flag_clr | input | 1 | Clears the start-observed flag |
| stop_flag_clr | input | 1 | Clears the stop-observed flag |
| scl_i | input | 1 | Sampled clock wire |
| sda_i | input | 1 | Sampled data wire |
| scl_oe | output | 1 | 1 pulls the clock wire low |
| sda_oe | output | 1 | 1 pulls the data wire low |
| start_pending | output | 1 | Start request armed and not yet driven |
| stop_pending | output | 1 | Stop request armed and not yet completed |
| start_seen | output | 1 | Sticky start-observed flag |
| stop_seen | output | 1 | Sticky stop-observed flag |
| bit_count | output | $clog2(FRAME_BITS+1) | Clock position within the current frame, 0 before the first edge |
| ack_slot | output | 1 | Current clock is the acknowledge clock |

## Verification
The assertions assume that no other device pulls the clock wire while the controller releases data to finish a stop. They also assume that a data edge is never seen at the same synchronized sample as a clock edge. The bench keeps to this by waiting several cycles between every external clock move and data move. It also pulls the clock low only during phases in which the controller is itself driving or releasing the clock, never during a stop.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;

    typedef enum logic [3:0] {
        GS_IDLE,
        GS_START_SDA,
        GS_START_SCL,
        GS_CLK_LOW,
        GS_CLK_WAIT,
        GS_CLK_HIGH,
        GS_STOP_LOW,
        GS_STOP_RISE,
        GS_STOP_HOLD
    } gen_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic start_ev;
        logic stop_ev;
    } bus_evt_t;

endpackage

// File: rtl/i2cc_line_sync.sv
module i2cc_line_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES*WIDTH){RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2cc_cond_detect.sv
module i2cc_cond_detect
    import i2cc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    input  logic     start_clr,
    input  logic     stop_clr,
    output bus_evt_t evt,
    output logic     start_seen,
    output logic     stop_seen
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic start_seen;
        logic stop_seen;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~det_q.scl_p;
        evt.start_ev = scl_s & det_q.scl_p & det_q.sda_p & ~sda_s;
        evt.stop_ev  = scl_s & det_q.scl_p & ~det_q.sda_p & sda_s;

        det_d       = det_q;
        det_d.scl_p = scl_s;
        det_d.sda_p = sda_s;
        if (start_clr) det_d.start_seen = 1'b0;
        if (stop_clr)  det_d.stop_seen  = 1'b0;
        if (evt.start_ev) begin
            det_d.start_seen = 1'b1;
            det_d.stop_seen  = 1'b0;
        end
        if (evt.stop_ev) begin
            det_d.stop_seen  = 1'b1;
            det_d.start_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '{scl_p: 1'b1, sda_p: 1'b1, start_seen: 1'b0, stop_seen: 1'b1};
        else        det_q <= det_d;
    end

    assign start_seen = det_q.start_seen;
    assign stop_seen  = det_q.stop_seen;
endmodule

// File: rtl/i2cc_frame_cnt.sv
module i2cc_frame_cnt
    import i2cc_pkg::*;
#(
    parameter int FRAME_BITS = 9,
    localparam int CW = $clog2(FRAME_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_evt_t      evt,
    output logic [CW-1:0] count,
    output logic          ack_slot
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ack;
    } fc_t;

    fc_t fc_d, fc_q;

    always_comb begin
        fc_d = fc_q;
        if (evt.start_ev || evt.stop_ev) begin
            fc_d.cnt = '0;
        end else if (evt.scl_rise) begin
            fc_d.cnt = (fc_q.cnt == LAST) ? CW'(1) : fc_q.cnt + CW'(1);
        end
        fc_d.ack = (fc_d.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fc_q <= '0;
        else        fc_q <= fc_d;
    end

    assign count    = fc_q.cnt;
    assign ack_slot = fc_q.ack;
endmodule

// File: rtl/i2cc_bus_gen.sv
module i2cc_bus_gen
    import i2cc_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int LOW_CYC  = 6,
    parameter int HIGH_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic scl_s,
    input  logic sda_s,
    input  logic stop_seen,
    output logic scl_oe,
    output logic sda_oe,
    output logic start_pending,
    output logic stop_pending
);
    localparam int MAX_CYC = (HOLD_CYC > LOW_CYC)
                           ? ((HOLD_CYC > HIGH_CYC) ? HOLD_CYC : HIGH_CYC)
                           : ((LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC);
    localparam int TW = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] HOLD_END = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] LOW_END  = TW'(LOW_CYC - 1);
    localparam logic [TW-1:0] HIGH_END = TW'(HIGH_CYC - 1);

    typedef struct packed {
        gen_state_e    state;
        logic [TW-1:0] tmr;
        logic          start_pend;
        logic          stop_pend;
    } gen_t;

    gen_t g_d, g_q;
    logic start_done, stop_done;

    always_comb begin
        g_d        = g_q;
        start_done = 1'b0;
        stop_done  = 1'b0;
        g_d.tmr    = g_q.tmr + TW'(1);

        unique case (g_q.state)
            GS_IDLE: begin
                g_d.tmr = '0;
                if (g_q.start_pend && stop_seen && scl_s && sda_s) begin
                    g_d.state = GS_START_SDA;
                end
            end
            GS_START_SDA: begin
                if (g_q.tmr == HOLD_END) begin
                    g_d.state = GS_START_SCL;
                    g_d.tmr   = '0;
                end
            end
            GS_START_SCL: begin
                g_d.tmr = '0;
                if (!scl_s) begin
                    g_d.state  = GS_CLK_LOW;
                    start_done = 1'b1;
                end
            end
            GS_CLK_LOW: begin
                if (g_q.tmr == LOW_END) begin
                    g_d.tmr   = '0;
                    g_d.state = g_q.stop_pend ? GS_STOP_LOW : GS_CLK_WAIT;
                end
            end
            GS_CLK_WAIT: begin
                g_d.tmr = '0;
                if (scl_s) g_d.state = GS_CLK_HIGH;
            end
            GS_CLK_HIGH: begin
                if (g_q.tmr == HIGH_END) begin
                    g_d.state = GS_CLK_LOW;
                    g_d.tmr   = '0;
                end
            end
            GS_STOP_LOW: begin
                if (g_q.tmr == LOW_END) begin
                    g_d.state = GS_STOP_RISE;
                    g_d.tmr   = '0;
                end
            end
            GS_STOP_RISE: begin
                g_d.tmr = '0;
                if (scl_s) g_d.state = GS_STOP_HOLD;
            end
            GS_STOP_HOLD: begin
                if (g_q.tmr == HOLD_END) begin
                    g_d.state = GS_IDLE;
                    g_d.tmr   = '0;
                    stop_done = 1'b1;
                end
            end
            default: begin
                g_d.state = GS_IDLE;
                g_d.tmr   = '0;
            end
        endcase

        g_d.start_pend = (start_done ? 1'b0 : g_q.start_pend) | start_req;
        g_d.stop_pend  = (stop_done ? 1'b0 : g_q.stop_pend)
                       | (stop_req && (g_q.state != GS_IDLE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{state: GS_IDLE, tmr: '0, start_pend: 1'b0, stop_pend: 1'b0};
        else        g_q <= g_d;
    end

    always_comb begin
        scl_oe = (g_q.state == GS_START_SCL) || (g_q.state == GS_CLK_LOW)
              || (g_q.state == GS_STOP_LOW);
        sda_oe = (g_q.state == GS_START_SDA) || (g_q.state == GS_START_SCL)
              || (g_q.state == GS_STOP_LOW)  || (g_q.state == GS_STOP_RISE)
              || (g_q.state == GS_STOP_HOLD);
    end

    assign start_pending = g_q.start_pend;
    assign stop_pending  = g_q.stop_pend;

    logic unused_sda;
    assign unused_sda = sda_s;
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
    import i2cc_pkg::*;
#(
    parameter int HOLD_CYC    = 4,
    parameter int LOW_CYC     = 6,
    parameter int HIGH_CYC    = 6,
    parameter int FRAME_BITS  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_req,
    input  logic                              stop_req,
    input  logic                              start_flag_clr,
    input  logic                              stop_flag_clr,
    input  logic                              scl_i,
    input  logic                              sda_i,
    output logic                              scl_oe,
    output logic                              sda_oe,
    output logic                              start_pending,
    output logic                              stop_pending,
    output logic                              start_seen,
    output logic                              stop_seen,
    output logic [$clog2(FRAME_BITS+1)-1:0]   bit_count,
    output logic                              ack_slot
);
    logic [1:0] lines_s;
    bus_evt_t   evt;

    i2cc_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_i, sda_i}),
        .q    (lines_s)
    );

    i2cc_cond_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .start_clr (start_flag_clr),
        .stop_clr  (stop_flag_clr),
        .evt       (evt),
        .start_seen(start_seen),
        .stop_seen (stop_seen)
    );

    i2cc_frame_cnt #(.FRAME_BITS(FRAME_BITS)) u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .count   (bit_count),
        .ack_slot(ack_slot)
    );

    i2cc_bus_gen #(.HOLD_CYC(HOLD_CYC), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .stop_req     (stop_req),
        .scl_s        (lines_s[1]),
        .sda_s        (lines_s[0]),
        .stop_seen    (stop_seen),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe),
        .start_pending(start_pending),
        .stop_pending (stop_pending)
    );
endmodule

// File: rtl/i2cc_checker.sv
module i2cc_checker #(
    parameter int FRAME_BITS = 9
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            scl_i,
    input logic                            scl_oe,
    input logic                            sda_oe,
    input logic                            start_pending,
    input logic                            start_seen,
    input logic                            stop_seen,
    input logic [$clog2(FRAME_BITS+1)-1:0] bit_count,
    input logic                            ack_slot
);
    localparam int CW = $clog2(FRAME_BITS + 1);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen)); // R3

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count <= CW'(FRAME_BITS)); // R9

    AST_ACK_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_slot) |-> $past(bit_count) == CW'(FRAME_BITS - 1)); // R9

    AST_START_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pending && $rose(sda_oe) && !scl_oe) |-> $past(stop_seen)); // R5

    AST_SDA_BEFORE_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pending && $rose(scl_oe)) |-> sda_oe); // R6

    AST_STOP_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> scl_i); // R10
endmodule

bind i2c_cond_ctrl i2cc_checker #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .start_pending(start_pending),
    .start_seen   (start_seen),
    .stop_seen    (stop_seen),
    .bit_count    (bit_count),
    .ack_slot     (ack_slot)
);

// File: tb/tb_i2c_cond_ctrl.sv
module tb_i2c_cond_ctrl;
    localparam int HOLD  = 4;
    localparam int LOWC  = 6;
    localparam int HIGHC = 6;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, stop_req = 1'b0;
    logic start_flag_clr = 1'b0, stop_flag_clr = 1'b0;
    logic tb_scl_lo = 1'b0, tb_sda_lo = 1'b0;
    logic scl_i, sda_i, scl_oe, sda_oe;
    logic start_pending, stop_pending, start_seen, stop_seen, ack_slot;
    logic [3:0] bit_count;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign scl_i = ~(scl_oe | tb_scl_lo);
    assign sda_i = ~(sda_oe | tb_sda_lo);

    i2c_cond_ctrl #(.HOLD_CYC(HOLD), .LOW_CYC(LOWC), .HIGH_CYC(HIGHC),
                    .FRAME_BITS(9), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .start_flag_clr(start_flag_clr), .stop_flag_clr(stop_flag_clr),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .start_pending(start_pending), .stop_pending(stop_pending),
        .start_seen(start_seen), .stop_seen(stop_seen),
        .bit_count(bit_count), .ack_slot(ack_slot));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 start_seen", start_seen, 0);
        chk("R1 stop_seen", stop_seen, 1);
        chk("R1 bit_count", bit_count, 0);
        chk("R1 ack_slot", ack_slot, 0);
        chk("R1 pendings", {start_pending, stop_pending}, 0);
    endtask

    task automatic t_ext_frame;
        tb_sda_lo = 1'b1; step(8);
        chk("R2 start_seen", start_seen, 1);
        chk("R2 stop_seen cleared", stop_seen, 0);
        chk("R9 count after start", bit_count, 0);
        tb_scl_lo = 1'b1; step(6);
        tb_sda_lo = 1'b0; step(6);
        tb_sda_lo = 1'b1; step(6);
        tb_sda_lo = 1'b0; step(6);
        chk("R2 data under low clock start_seen", start_seen, 1);
        chk("R2 data under low clock stop_seen", stop_seen, 0);
        for (int i = 1; i <= 10; i++) begin
            tb_scl_lo = 1'b0; step(6);
            chk("R9 bit_count", bit_count, (i == 10) ? 1 : i);
            chk("R9 ack_slot", ack_slot, (i == 9) ? 1 : 0);
            tb_scl_lo = 1'b1; step(6);
        end
        tb_sda_lo = 1'b1; step(6);
        tb_scl_lo = 1'b0; step(6);
        tb_sda_lo = 1'b0; step(6);
        chk("R3 stop_seen", stop_seen, 1);
        chk("R3 start_seen cleared", start_seen, 0);
        chk("R9 count after stop", bit_count, 0);
    endtask

    task automatic t_idle_stop;
        stop_req = 1'b1; step(1); stop_req = 1'b0; step(10);
        chk("R11 stop_pending", stop_pending, 0);
        chk("R11 lines", {scl_oe, sda_oe}, 0);
        chk("R11 stop_seen kept", stop_seen, 1);
    endtask

    task automatic t_clear_and_pend;
        stop_flag_clr = 1'b1; step(1); stop_flag_clr = 1'b0; step(1);
        chk("R4 stop_seen cleared", stop_seen, 0);
        tb_sda_lo = 1'b1; step(8);
        chk("R2 start_seen", start_seen, 1);
        start_flag_clr = 1'b1; step(1); start_flag_clr = 1'b0; step(1);
        chk("R4 start_seen cleared", start_seen, 0);
        start_req = 1'b1; step(1); start_req = 1'b0; step(30);
        chk("R5 start_pending", start_pending, 1);
        chk("R5 lines idle", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_launch;
        int t;
        int gap;
        t = 0;
        tb_sda_lo = 1'b0;
        while (!sda_oe && t < 100) begin step(1); t++; end
        chk("R6 sda_oe rises", sda_oe, 1);
        chk("R6 scl_oe still 0", scl_oe, 0);
        gap = 0;
        while (!scl_oe && gap < 100) begin step(1); gap++; end
        chk("R6 hold cycles", gap, HOLD);
        step(6);
        chk("R6 start_pending cleared", start_pending, 0);
        chk("R6 own start seen", start_seen, 1);
    endtask

    task automatic t_clock_shape;
        int lo;
        int hi;
        int t;
        t = 0;
        while (scl_oe && t < 100) begin step(1); t++; end
        while (!scl_oe && t < 200) begin step(1); t++; end
        lo = 0;
        while (scl_oe && lo < 100) begin step(1); lo++; end
        hi = 0;
        while (!scl_oe && hi < 100) begin step(1); hi++; end
        chk("R7 low length", lo, LOWC);
        chk("R7 high length", hi, HIGHC + SYNC + 1);
    endtask

    task automatic t_stretch;
        int t;
        int old;
        int bad;
        t = 0;
        while (!scl_oe && t < 100) begin step(1); t++; end
        tb_scl_lo = 1'b1;
        t = 0;
        while (scl_oe && t < 100) begin step(1); t++; end
        old = bit_count;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (scl_oe || bit_count != old) bad++;
        end
        chk("R8 frozen while stretched", bad, 0);
        tb_scl_lo = 1'b0; step(8);
        chk("R8 advances after release", bit_count, (old == 9) ? 1 : old + 1);
    endtask

    task automatic t_stop;
        int t;
        int scl_at_fall;
        logic prev;
        scl_at_fall = -1;
        stop_req = 1'b1; step(1); stop_req = 1'b0;
        chk("R10 stop_pending set", stop_pending, 1);
        prev = sda_oe;
        t = 0;
        while (!stop_seen && t < 300) begin
            step(1); t++;
            if (prev && !sda_oe) scl_at_fall = scl_oe;
            prev = sda_oe;
        end
        step(2);
        chk("R10 scl released at data release", scl_at_fall, 0);
        chk("R10 stop_seen", stop_seen, 1);
        chk("R10 start_seen cleared", start_seen, 0);
        chk("R10 bit_count", bit_count, 0);
        chk("R10 lines released", {scl_oe, sda_oe}, 0);
        chk("R10 stop_pending cleared", stop_pending, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_ext_frame();
        t_idle_stop();
        t_clear_and_pend();
        t_launch();
        t_clock_shape();
        t_stretch();
        t_stop();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule